// File: doc/BRIEF.md
# Code-Density Histogram Calibrator

This block measures the non-linearity of a fine time interpolator by code-density testing. Hits that arrive at random moments, uncorrelated with the clock and at a low rate, should land in every fine code with a probability proportional to that code's true width. The block counts the hits that fall in each bin. It stops by itself once the histogram holds, on average, `HITS_PER_BIN` hits for each bin in use. The default is 1000.

Once acquisition has finished, a readout pass walks the active bins in ascending order, one bin per clock. For each bin it presents the raw count, the differential non-linearity (DNL) and the integral non-linearity (INL). DNL is the bin's width error measured in LSB. INL is the running sum of DNL, starting from bin 0. Firmware loads these values into the correction tables of the converter.

The number of active bins is the clock period divided by the nominal LSB. It drifts with temperature, so it is an input that is sampled when acquisition starts. The controller is a five-state machine:
- `ST_IDLE`: waits for a command.
- `ST_CLEAR`: zeroes the counters one per cycle.
- `ST_ACQ`: accumulates hits.
- `ST_DONE`: holds the finished histogram.
- `ST_READ`: streams the results.

The transitions are:
- IDLE→CLEAR on clear, and IDLE→ACQ on start. Clear wins if both arrive together.
- CLEAR→IDLE after the last counter has been zeroed.
- ACQ→DONE on the hit that reaches the goal, and ACQ→CLEAR on clear (abort).
- DONE→READ on a readout request, and DONE→CLEAR on clear.
- READ→DONE after the last active bin.

Top module: `cdh_calib`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `ovf_o` and `rd_vld_o` are low and every bin count is zero.
- R2: A clear sampled in IDLE, ACQ or DONE takes effect as follows. `busy_o` rises in the next cycle and stays high for exactly `MAX_BINS` cycles. Afterwards every count and the hit total are zero and `ovf_o` is low. Clear has priority over a start in the same cycle. A hit in the same cycle as the clear is not counted.
- R3: A start sampled in IDLE latches `nbins_i` (legal values 1..`MAX_BINS`) as the active bin count N. While in ACQ, each cycle with `code_vld_i` high and `code_i` < N adds one to that bin and one to the total. A code ≥ N, or a cycle with the strobe low, changes nothing.
- R4: `done_o` rises in the cycle after the accepted hit that brings the total to `HITS_PER_BIN`×N. It stays high until a readout or clear, and hits presented while done are not counted.
- R5: A bin count never exceeds 2^`CNT_W`−1 (65535). A hit that lands on a full bin still adds to the total and sets `ovf_o`, which stays high until the next clear.
- R6: A readout request sampled while done produces N consecutive cycles of `rd_vld_o`, with `rd_bin_o` running 0..N−1 and `rd_cnt_o` giving that bin's count.
- R7: For each bin, `rd_dnl_o` = floor(count×N×2^`FRAC_W` / total) − 2^`FRAC_W`. This is a signed value with `FRAC_W` (8) fractional bits, so 256 means 1 LSB.
- R8: `rd_inl_o` equals the sum of `rd_dnl_o` over bins 0 up to and including the current bin. It is sign-extended to one bit wider than `rd_dnl_o`.
- R9: After the last bin the block returns to done with `done_o` high. A readout request outside the done state produces no `rd_vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Zero the histogram, aborting any acquisition |
| start_i | input | 1 | Begin acquisition (honoured in IDLE) |
| nbins_i | input | 9 | Active bin count N, sampled on start |
| code_vld_i | input | 1 | Fine code strobe |
| code_i | input | 8 | Fine code of the hit |
| rd_start_i | input | 1 | Request a readout pass (honoured while done) |
| busy_o | output | 1 | Clear in progress |
| done_o | output | 1 | Histogram complete |
| ovf_o | output | 1 | Some bin count saturated |
| rd_vld_o | output | 1 | Readout beat valid |
| rd_bin_o | output | 8 | Bin index of the beat |
| rd_cnt_o | output | 16 | Hit count of the bin |
| rd_dnl_o | output | 18 | Signed DNL, 8 fractional bits |
| rd_inl_o | output | 19 | Signed INL, 8 fractional bits |

## Verification
In ACQ, a clear and an accepted hit can fall in the same cycle, and the clear must win with the hit lost. The bench provokes this by raising `clear_i` and `code_vld_i` together midway through a run. It checks that `busy_o` follows in the next cycle, and that the readout after a fresh run shows no trace of the hits from before the abort. The same race is driven in IDLE between clear and start, and there the check is that the clear sequence starts instead of an acquisition.

// File: rtl/cdh_pkg.sv
package cdh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ACQ,
        ST_DONE,
        ST_READ
    } cdh_state_e;

endpackage

// File: rtl/cdh_bank.sv
// Per-bin saturating hit counters with a sequential clear port and a read port.
module cdh_bank #(
    parameter int MAX_BINS = 256,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = $clog2(MAX_BINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en_i,
    input  logic [IDX_W-1:0] clr_idx_i,
    input  logic             inc_en_i,
    input  logic [IDX_W-1:0] inc_idx_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [CNT_W-1:0] rd_cnt_o,
    output logic             sat_o
);

    logic [CNT_W-1:0] cnt_q [MAX_BINS];
    logic             full;

    assign full     = (cnt_q[inc_idx_i] == {CNT_W{1'b1}});
    assign sat_o    = inc_en_i && full;
    assign rd_cnt_o = cnt_q[rd_idx_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_BINS; i++) begin
                cnt_q[i] <= '0;
            end
        end else if (clr_en_i) begin
            cnt_q[clr_idx_i] <= '0;
        end else if (inc_en_i && !full) begin
            cnt_q[inc_idx_i] <= cnt_q[inc_idx_i] + 1'b1;
        end
    end

endmodule

// File: rtl/cdh_dnl.sv
// Combinational DNL of one bin: floor(cnt*nb*2^F/total) - 2^F, signed.
module cdh_dnl #(
    parameter int CNT_W    = 16,
    parameter int BIN_W    = 9,
    parameter int TOT_W    = 32,
    parameter int FRAC_W   = 8,
    localparam int DNL_W   = BIN_W + FRAC_W + 1
) (
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [BIN_W-1:0]        nb_i,
    input  logic [TOT_W-1:0]        total_i,
    output logic signed [DNL_W-1:0] dnl_o
);

    localparam int PROD_W = CNT_W + BIN_W;
    localparam int NUM_W  = PROD_W + FRAC_W;
    localparam int DIV_W  = (NUM_W > TOT_W) ? NUM_W : TOT_W;

    logic [PROD_W-1:0]  prod;
    logic [DIV_W-1:0]   num;
    logic [DIV_W-1:0]   den;
    logic [DIV_W-1:0]   quot;
    logic [DNL_W-2:0]   ratio;

    always_comb begin
        prod = PROD_W'(cnt_i) * PROD_W'(nb_i);
        num  = DIV_W'({prod, {FRAC_W{1'b0}}});
        den  = DIV_W'(total_i);
        quot = (den == '0) ? '0 : (num / den);
        // The ratio cannot exceed nb when cnt <= total; clamp for safety.
        if (|quot[DIV_W-1:DNL_W-1]) begin
            ratio = {(DNL_W-1){1'b1}};
        end else begin
            ratio = quot[DNL_W-2:0];
        end
        dnl_o = $signed({1'b0, ratio}) - $signed(DNL_W'(1 << FRAC_W));
    end

endmodule

// File: rtl/cdh_ctrl.sv
// Sequencer: clear walk, acquisition with goal detection, readout walk.
module cdh_ctrl
    import cdh_pkg::*;
#(
    parameter int MAX_BINS     = 256,
    parameter int TOT_W        = 32,
    parameter int HITS_PER_BIN = 1000,
    localparam int IDX_W       = $clog2(MAX_BINS),
    localparam int BIN_W       = $clog2(MAX_BINS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             start_i,
    input  logic             rd_start_i,
    input  logic [BIN_W-1:0] nbins_i,
    input  logic             code_vld_i,
    input  logic [IDX_W-1:0] code_i,
    input  logic             sat_i,
    output logic             inc_en_o,
    output logic             clr_en_o,
    output logic             rd_act_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             ovf_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [BIN_W-1:0] nb_o,
    output logic [TOT_W-1:0] total_o
);

    cdh_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [BIN_W-1:0] nb_q;
    logic [TOT_W-1:0] total_q;
    logic             ovf_q;

    logic             hit_ok;
    logic [TOT_W-1:0] goal;
    logic [TOT_W-1:0] total_nxt;
    logic             clr_last;
    logic             rd_last;
    logic             clr_go;

    assign hit_ok    = code_vld_i && (BIN_W'(code_i) < nb_q);
    assign goal      = TOT_W'(HITS_PER_BIN) * TOT_W'(nb_q);
    assign total_nxt = total_q + 1'b1;
    assign clr_last  = (idx_q == IDX_W'(MAX_BINS - 1));
    assign rd_last   = (BIN_W'(idx_q) == (nb_q - 1'b1));
    assign clr_go    = (state_d == ST_CLEAR) && (state_q != ST_CLEAR);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (clear_i)      state_d = ST_CLEAR;
                else if (start_i) state_d = ST_ACQ;
            end
            ST_CLEAR: begin
                if (clr_last)     state_d = ST_IDLE;
            end
            ST_ACQ: begin
                if (clear_i)                              state_d = ST_CLEAR;
                else if (hit_ok && (total_nxt >= goal))   state_d = ST_DONE;
            end
            ST_DONE: begin
                if (clear_i)         state_d = ST_CLEAR;
                else if (rd_start_i) state_d = ST_READ;
            end
            ST_READ: begin
                if (rd_last)      state_d = ST_DONE;
            end
            default:              state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        inc_en_o = (state_q == ST_ACQ) && hit_ok && !clear_i;
        clr_en_o = (state_q == ST_CLEAR);
        rd_act_o = (state_q == ST_READ);
        busy_o   = (state_q == ST_CLEAR);
        done_o   = (state_q == ST_DONE);
        ovf_o    = ovf_q;
        idx_o    = idx_q;
        nb_o     = nb_q;
        total_o  = total_q;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            nb_q    <= '0;
            total_q <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                idx_q <= '0;
            end else if ((state_q == ST_CLEAR) || (state_q == ST_READ)) begin
                idx_q <= idx_q + 1'b1;
            end

            if ((state_q == ST_IDLE) && !clear_i && start_i) begin
                nb_q <= nbins_i;
            end

            if (clr_go) begin
                total_q <= '0;
                ovf_q   <= 1'b0;
            end else if (inc_en_o) begin
                total_q <= total_nxt;
                if (sat_i) ovf_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cdh_calib.sv
// Code-density histogram calibrator: top level with readout stage.
module cdh_calib #(
    parameter int MAX_BINS     = 256,
    parameter int CNT_W        = 16,
    parameter int TOT_W        = 32,
    parameter int FRAC_W       = 8,
    parameter int HITS_PER_BIN = 1000,
    localparam int IDX_W       = $clog2(MAX_BINS),
    localparam int BIN_W       = $clog2(MAX_BINS + 1),
    localparam int DNL_W       = BIN_W + FRAC_W + 1,
    localparam int INL_W       = DNL_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    start_i,
    input  logic [BIN_W-1:0]        nbins_i,
    input  logic                    code_vld_i,
    input  logic [IDX_W-1:0]        code_i,
    input  logic                    rd_start_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    ovf_o,
    output logic                    rd_vld_o,
    output logic [IDX_W-1:0]        rd_bin_o,
    output logic [CNT_W-1:0]        rd_cnt_o,
    output logic signed [DNL_W-1:0] rd_dnl_o,
    output logic signed [INL_W-1:0] rd_inl_o
);

    logic                    inc_en;
    logic                    clr_en;
    logic                    rd_act;
    logic                    sat;
    logic [IDX_W-1:0]        idx;
    logic [BIN_W-1:0]        nb;
    logic [TOT_W-1:0]        total;
    logic [CNT_W-1:0]        bin_cnt;
    logic signed [DNL_W-1:0] dnl;
    logic signed [INL_W-1:0] dnl_ext;
    logic signed [INL_W-1:0] inl_base;

    cdh_ctrl #(
        .MAX_BINS    (MAX_BINS),
        .TOT_W       (TOT_W),
        .HITS_PER_BIN(HITS_PER_BIN)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .start_i    (start_i),
        .rd_start_i (rd_start_i),
        .nbins_i    (nbins_i),
        .code_vld_i (code_vld_i),
        .code_i     (code_i),
        .sat_i      (sat),
        .inc_en_o   (inc_en),
        .clr_en_o   (clr_en),
        .rd_act_o   (rd_act),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .ovf_o      (ovf_o),
        .idx_o      (idx),
        .nb_o       (nb),
        .total_o    (total)
    );

    cdh_bank #(
        .MAX_BINS(MAX_BINS),
        .CNT_W   (CNT_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en_i  (clr_en),
        .clr_idx_i (idx),
        .inc_en_i  (inc_en),
        .inc_idx_i (code_i),
        .rd_idx_i  (idx),
        .rd_cnt_o  (bin_cnt),
        .sat_o     (sat)
    );

    cdh_dnl #(
        .CNT_W (CNT_W),
        .BIN_W (BIN_W),
        .TOT_W (TOT_W),
        .FRAC_W(FRAC_W)
    ) u_dnl (
        .cnt_i   (bin_cnt),
        .nb_i    (nb),
        .total_i (total),
        .dnl_o   (dnl)
    );

    assign dnl_ext  = INL_W'(dnl);
    assign inl_base = (idx == '0) ? '0 : rd_inl_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld_o <= 1'b0;
            rd_bin_o <= '0;
            rd_cnt_o <= '0;
            rd_dnl_o <= '0;
            rd_inl_o <= '0;
        end else begin
            rd_vld_o <= rd_act;
            if (rd_act) begin
                rd_bin_o <= idx;
                rd_cnt_o <= bin_cnt;
                rd_dnl_o <= dnl;
                rd_inl_o <= inl_base + dnl_ext;
            end
        end
    end

endmodule

// File: rtl/cdh_calib_chk.sv
module cdh_calib_chk #(
    parameter int IDX_W = 8,
    parameter int DNL_W = 18,
    parameter int INL_W = 19
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clear_i,
    input logic                    rd_start_i,
    input logic                    busy_o,
    input logic                    done_o,
    input logic                    ovf_o,
    input logic                    rd_vld_o,
    input logic [IDX_W-1:0]        rd_bin_o,
    input logic signed [DNL_W-1:0] rd_dnl_o,
    input logic signed [INL_W-1:0] rd_inl_o
);

    AST_BUSY_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R2

    AST_BUSY_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(clear_i)); // R2

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i && !rd_start_i) |=> done_o); // R4

    AST_OVF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_o) |-> busy_o); // R5

    AST_FIRST_BIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_vld_o) |-> (rd_bin_o == '0)); // R6

    AST_BIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld_o && $past(rd_vld_o)) |-> (rd_bin_o == $past(rd_bin_o) + 1'b1)); // R6

    AST_INL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_vld_o) |-> (rd_inl_o == INL_W'(rd_dnl_o))); // R8

    AST_INL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld_o && $past(rd_vld_o)) |-> (rd_inl_o == $past(rd_inl_o) + INL_W'(rd_dnl_o))); // R8

endmodule

bind cdh_calib cdh_calib_chk #(
    .IDX_W(IDX_W),
    .DNL_W(DNL_W),
    .INL_W(INL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .rd_start_i(rd_start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ovf_o     (ovf_o),
    .rd_vld_o  (rd_vld_o),
    .rd_bin_o  (rd_bin_o),
    .rd_dnl_o  (rd_dnl_o),
    .rd_inl_o  (rd_inl_o)
);

// File: tb/sim_cdh_calib.sv
module sim_cdh_calib;

    localparam int CLK_PERIOD = 10;
    localparam int NBINS_MAX  = 256;
    localparam int GOAL_PER   = 1000;
    localparam int CNT_MAX    = 65535;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clear_i = 1'b0;
    logic               start_i = 1'b0;
    logic [8:0]         nbins_i = '0;
    logic               code_vld_i = 1'b0;
    logic [7:0]         code_i = '0;
    logic               rd_start_i = 1'b0;
    logic               busy_o, done_o, ovf_o, rd_vld_o;
    logic [7:0]         rd_bin_o;
    logic [15:0]        rd_cnt_o;
    logic signed [17:0] rd_dnl_o;
    logic signed [18:0] rd_inl_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdh_calib u0 (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .start_i(start_i),
        .nbins_i(nbins_i), .code_vld_i(code_vld_i), .code_i(code_i),
        .rd_start_i(rd_start_i), .busy_o(busy_o), .done_o(done_o),
        .ovf_o(ovf_o), .rd_vld_o(rd_vld_o), .rd_bin_o(rd_bin_o),
        .rd_cnt_o(rd_cnt_o), .rd_dnl_o(rd_dnl_o), .rd_inl_o(rd_inl_o)
    );

    typedef struct {
        int     bin;
        int     cnt;
        longint dnl;
        longint inl;
    } beat_t;

    beat_t  exp_q[$];
    int     n_chk = 0;
    int     n_bad = 0;
    bit     ended = 0;

    int     mdl_cnt [NBINS_MAX];
    int     mdl_nb = 0;
    longint mdl_total = 0;
    bit     mdl_acq = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: one call per cycle, inputs change at the falling edge.
    task automatic step(input bit vld, input int code, input bit clr, input bit st, input bit rd);
        @(negedge clk);
        code_vld_i = vld;
        code_i     = 8'(code);
        clear_i    = clr;
        start_i    = st;
        rd_start_i = rd;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0);
    endtask

    // R3/R4/R5 model of one presented hit
    task automatic hit(input int code, input bit vld);
        step(vld, code, 0, 0, 0);
        if (vld && mdl_acq && code < mdl_nb) begin
            mdl_total++;
            if (mdl_cnt[code] < CNT_MAX) mdl_cnt[code]++;
            if (mdl_total == longint'(GOAL_PER) * mdl_nb) mdl_acq = 0;
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NBINS_MAX; i++) mdl_cnt[i] = 0;
        mdl_total = 0;
        mdl_acq   = 0;
    endtask

    // R2: clear (optionally racing a hit or a start) and measure busy length
    task automatic do_clear(input bit with_hit, input bit with_start, input string tag);
        int busy_len;
        busy_len = 0;
        step(with_hit, 1, 1, with_start, 0);
        model_clear();
        idle();
        chk(busy_o === 1'b1, {tag, " busy after clear"}, busy_o, 1);
        while (busy_o === 1'b1 && busy_len < 2 * NBINS_MAX) begin
            busy_len++;
            idle();
        end
        chk(busy_len == NBINS_MAX, {tag, " busy length"}, busy_len, NBINS_MAX);
        chk(ovf_o === 1'b0 && done_o === 1'b0, {tag, " flags after clear"}, {ovf_o, done_o}, 0);
    endtask

    task automatic do_start(input int nb);
        step(0, 0, 0, 1, 0);
        nbins_i = 9'(nb);
        mdl_nb  = nb;
        mdl_acq = 1;
        idle();
    endtask

    // Scoreboard driver: push expected beats, then request readout (R6-R9)
    task automatic readout(input string tag);
        longint run;
        int     guard;
        run = 0;
        for (int b = 0; b < mdl_nb; b++) begin
            beat_t e;
            e.bin = b;
            e.cnt = mdl_cnt[b];
            e.dnl = ((longint'(mdl_cnt[b]) * mdl_nb) <<< 8) / mdl_total - 256;
            run  += e.dnl;
            e.inl = run;
            exp_q.push_back(e);
        end
        step(0, 0, 0, 0, 1);
        guard = 0;
        while (exp_q.size() != 0 && guard < mdl_nb + 8) begin
            guard++;
            idle();
        end
        chk(exp_q.size() == 0, {tag, " R6 all beats seen"}, exp_q.size(), 0);
        exp_q.delete();
        idle();
        chk(done_o === 1'b1, {tag, " R9 done after readout"}, done_o, 1);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rd_vld_o === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R9 unexpected readout beat", rd_bin_o, -1);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk(int'(rd_bin_o) == e.bin, "R6 bin index", rd_bin_o, e.bin);
                    chk(int'(rd_cnt_o) == e.cnt, "R6 bin count", rd_cnt_o, e.cnt);
                    chk(longint'(rd_dnl_o) == e.dnl, "R7 dnl", rd_dnl_o, e.dnl);
                    chk(longint'(rd_inl_o) == e.inl, "R8 inl", rd_inl_o, e.inl);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 200000);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int plan1 [4];
        int plan2 [3];
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();

        // R1 reset state
        chk(busy_o === 0 && done_o === 0 && ovf_o === 0 && rd_vld_o === 0,
            "R1 reset flags", {busy_o, done_o, ovf_o, rd_vld_o}, 0);

        // R9 readout request in IDLE is ignored (monitor flags any beat)
        step(0, 0, 0, 0, 1);
        repeat (4) idle();
        chk(done_o === 0, "R9 no done in idle", done_o, 0);

        // R2 clear, then run 1 with N=4 and a skewed histogram
        do_clear(0, 0, "R2 first");
        do_start(4);
        plan1 = '{1000, 1200, 800, 1000};
        for (int b = 0; b < 4; b++) begin
            for (int k = 0; k < plan1[b] - ((b == 3) ? 1 : 0); k++) begin
                hit(b, 1);
                if (k % 7 == 0) hit(9 + b, 1);     // R3 out of range
                if (k % 11 == 0) hit((b + 1) % 4, 0); // R3 strobe low
            end
        end
        idle();
        chk(done_o === 0, "R4 not done one hit early", done_o, 0);
        hit(3, 1);
        idle();
        chk(done_o === 1, "R4 done after goal", done_o, 1);
        for (int k = 0; k < 50; k++) hit(0, 1);   // R4 ignored while done
        idle();
        chk(ovf_o === 0, "R5 no overflow", ovf_o, 0);
        readout("run1");

        // R2 start racing clear in IDLE
        do_clear(0, 0, "R2 second");
        do_clear(0, 1, "R2 clear beats start");
        idle();
        chk(done_o === 0 && busy_o === 0, "R2 idle after race", {done_o, busy_o}, 0);

        // R2 abort: clear and hit in the same ACQ cycle
        do_start(3);
        for (int k = 0; k < 40; k++) hit(k % 3, 1);
        do_clear(1, 0, "R2 abort with hit");
        do_start(3);
        plan2 = '{900, 1100, 1000};
        for (int b = 0; b < 3; b++)
            for (int k = 0; k < plan2[b]; k++) hit(b, 1);
        idle();
        chk(done_o === 1, "R4 done run2", done_o, 1);
        readout("run2");

        // R5 saturation: N=70, all hits on bin 5
        do_clear(0, 0, "R2 third");
        do_start(70);
        for (int k = 0; k < 70000; k++) hit(5, 1);
        idle();
        chk(done_o === 1, "R4 done run3", done_o, 1);
        chk(ovf_o === 1, "R5 overflow set", ovf_o, 1);
        readout("run3 R5");
        do_clear(0, 0, "R5 overflow cleared");

        finish_run();
    end

endmodule